// File: doc/BRIEF.md
# Parallel DAC Host Write Sequencer

This block sits on the host side of a parallel-input digital-to-analog converter. It takes a code request through a valid/ready handshake and turns it into a timed sequence on the converter's bus pins: the data bus, an active-low write strobe, two active-low byte selects, an active-low load strobe and an active-low clear strobe. A mode bit chosen per request picks either one full-width write with both byte selects low, or two byte writes for an 8-bit bus, upper byte first. In both modes a single load pulse follows the last write.

Every strobe phase, and the quiet gap after each write, lasts a fixed number of system clocks. That number comes from two parameters, the clock period and the minimum strobe interval. It is the ceiling of their ratio and is never less than one. A separate clear input is latched and issued as a clear pulse between transactions. It wins over a write that is waiting in the same idle cycle.

Top module: `pdac_wr_seq`

## Requirements
- R1: After reset, the write, both byte selects, load and clear outputs are high, the data bus is all zeros and `req_ready` is high.
- R2: A request with `req_byte_mode`=0 produces one write phase. During it `dac_wr_n`, `dac_cs_hi_n` and `dac_cs_lo_n` are low together and `dac_data` equals the requested code.
- R3: A request with `req_byte_mode`=1 produces two write phases. The first has only `dac_cs_hi_n` low and carries code bits [15:8] on both halves of `dac_data`. The second has only `dac_cs_lo_n` low and carries bits [7:0] on both halves.
- R4: After the final write, a gap of PULSE_CLKS cycles with every strobe high is followed by one `dac_load_n` low pulse of exactly PULSE_CLKS cycles. Each write is also followed by such a gap.
- R5: Every write phase holds `dac_wr_n` and its byte selects low for exactly PULSE_CLKS cycles. `dac_data` is stable for the whole phase and stays unchanged through the following gap.
- R6: `req_ready` goes low in the cycle after a request is accepted. It returns high only in the cycle in which `dac_load_n` has gone back high. A request is accepted only on a clock edge where `req_valid` and `req_ready` are both high.
- R7: A `clr_req` pulse produces exactly one `dac_clear_n` low pulse of PULSE_CLKS cycles, with no write or load during it. If it arrives during a transaction, the pulse starts only after that transaction's load strobe has ended, and `req_ready` stays low until the clear pulse ends.
- R8: When `clr_req` and `req_valid` are both high in an idle cycle, `req_ready` is low. The clear pulse starts on the next edge, and the write is accepted only after the clear has finished.
- R9: PULSE_CLKS equals ceil(MIN_PULSE_PS / CLK_PERIOD_PS), and is at least 1. With the defaults (5000 ps, 60000 ps) it is 12.
- R10: At most one of `dac_wr_n`, `dac_load_n` and `dac_clear_n` is low in any cycle, and a byte select is low only while `dac_wr_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A code request is offered |
| req_ready | output | 1 | Sequencer idle with no clear pending; request will be taken |
| req_code | input | CODE_W | Code to send to the converter |
| req_byte_mode | input | 1 | 1 = two byte writes, 0 = one full-width write |
| clr_req | input | 1 | Request a clear pulse (single-cycle pulse or level) |
| dac_data | output | CODE_W | Registered converter data bus |
| dac_wr_n | output | 1 | Active-low write strobe |
| dac_cs_hi_n | output | 1 | Active-low upper byte select |
| dac_cs_lo_n | output | 1 | Active-low lower byte select |
| dac_load_n | output | 1 | Active-low load strobe |
| dac_clear_n | output | 1 | Active-low clear strobe |

## Verification
A wrong phase state or a wrong byte-order flag shows within one clock as a strobe that is high or low when it should not be. Examples are a missing second byte write, a load arriving one gap early, or a byte select left low during a gap. A phase counter that is off by one lengthens or shortens a strobe. This shows at the rising edge of that strobe, at most PULSE_CLKS cycles after the phase begins. A lost or doubled clear latch shows as a missing or extra clear pulse as soon as the sequencer next goes idle. It also shows as `req_ready` rising while a clear is still owed.

// File: rtl/pdac_wr_seq_pkg.sv
package pdac_wr_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_WRITE = 3'd1,
      ST_GAP   = 3'd2,
      ST_LOAD  = 3'd3,
      ST_CLEAR = 3'd4
   } seq_state_e;

   typedef enum logic [1:0] {
      LANE_WORD = 2'd0,
      LANE_HI   = 2'd1,
      LANE_LO   = 2'd2
   } lane_e;

   // ceiling of interval / period, floored at one clock
   function automatic int clks_per_interval(input int period_ps, input int interval_ps);
      int q;
      if (period_ps <= 0) return 1;
      q = (interval_ps + period_ps - 1) / period_ps;
      return (q < 1) ? 1 : q;
   endfunction

endpackage

// File: rtl/pdac_phase_timer.sv
module pdac_phase_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);

endmodule

// File: rtl/pdac_lane_drv.sv
module pdac_lane_drv
   import pdac_wr_seq_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter bit BYTE_MODE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              stop,
   input  lane_e             lane,
   input  logic [DATA_W-1:0] code,
   output logic [DATA_W-1:0] data,
   output logic              cs_hi_n,
   output logic              cs_lo_n
);

   localparam int HALF_W = DATA_W / 2;

   lane_e             eff_lane;
   logic [DATA_W-1:0] data_d;
   logic              hi_sel;
   logic              lo_sel;

   generate
      if (BYTE_MODE_EN) begin : g_split
         assign eff_lane = lane;
      end else begin : g_word_only
         assign eff_lane = LANE_WORD;
      end
   endgenerate

   always_comb begin
      data_d = code;
      hi_sel = 1'b1;
      lo_sel = 1'b1;
      unique case (eff_lane)
         LANE_HI: begin
            data_d = {code[DATA_W-1:HALF_W], code[DATA_W-1:HALF_W]};
            lo_sel = 1'b0;
         end
         LANE_LO: begin
            data_d = {code[HALF_W-1:0], code[HALF_W-1:0]};
            hi_sel = 1'b0;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data    <= '0;
         cs_hi_n <= 1'b1;
         cs_lo_n <= 1'b1;
      end else if (start) begin
         data    <= data_d;
         cs_hi_n <= ~hi_sel;
         cs_lo_n <= ~lo_sel;
      end else if (stop) begin
         cs_hi_n <= 1'b1;
         cs_lo_n <= 1'b1;
      end
   end

endmodule

// File: rtl/pdac_wr_seq.sv
module pdac_wr_seq
   import pdac_wr_seq_pkg::*;
#(
   parameter int CODE_W        = 16,
   parameter int CLK_PERIOD_PS = 5000,
   parameter int MIN_PULSE_PS  = 60000,
   parameter bit BYTE_MODE_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [CODE_W-1:0] req_code,
   input  logic              req_byte_mode,
   input  logic              clr_req,
   output logic [CODE_W-1:0] dac_data,
   output logic              dac_wr_n,
   output logic              dac_cs_hi_n,
   output logic              dac_cs_lo_n,
   output logic              dac_load_n,
   output logic              dac_clear_n
);

   localparam int               PULSE_CLKS = clks_per_interval(CLK_PERIOD_PS, MIN_PULSE_PS);
   localparam int               CNT_W      = $clog2(PULSE_CLKS + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD   = CNT_W'(PULSE_CLKS - 1);

   generate
      if (CODE_W < 2 || (CODE_W % 2) != 0) begin : g_bad_width
         $error("pdac_wr_seq: CODE_W must be even and at least 2");
      end
      if (CLK_PERIOD_PS <= 0 || MIN_PULSE_PS <= 0) begin : g_bad_timing
         $error("pdac_wr_seq: timing parameters must be positive");
      end
   endgenerate

   seq_state_e        state_q, state_d;
   logic              byte_q;
   logic              low_done_q;
   logic [CODE_W-1:0] code_q;
   logic              clr_pend_q;
   logic              clr_owed;
   logic              accept;
   logic              byte_req;
   logic              timer_done;
   logic              lane_start, lane_stop;
   lane_e             lane_sel;
   logic [CODE_W-1:0] lane_code;
   logic              wr_n_q, ld_n_q, clr_n_q;

   generate
      if (BYTE_MODE_EN) begin : g_mode_in
         assign byte_req = req_byte_mode;
      end else begin : g_mode_fixed
         assign byte_req = 1'b0;
      end
   endgenerate

   assign clr_owed  = clr_pend_q | clr_req;
   assign req_ready = (state_q == ST_IDLE) & ~clr_owed;
   assign accept    = req_ready & req_valid;

   always_comb begin
      state_d    = state_q;
      lane_start = 1'b0;
      lane_stop  = 1'b0;
      lane_sel   = LANE_WORD;
      lane_code  = code_q;
      unique case (state_q)
         ST_IDLE: begin
            if (clr_owed) begin
               state_d = ST_CLEAR;
            end else if (req_valid) begin
               state_d    = ST_WRITE;
               lane_start = 1'b1;
               lane_sel   = byte_req ? LANE_HI : LANE_WORD;
               lane_code  = req_code;
            end
         end
         ST_WRITE: begin
            if (timer_done) begin
               state_d   = ST_GAP;
               lane_stop = 1'b1;
            end
         end
         ST_GAP: begin
            if (timer_done) begin
               if (byte_q && !low_done_q) begin
                  state_d    = ST_WRITE;
                  lane_start = 1'b1;
                  lane_sel   = LANE_LO;
               end else begin
                  state_d = ST_LOAD;
               end
            end
         end
         ST_LOAD, ST_CLEAR: begin
            if (timer_done) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         byte_q     <= 1'b0;
         low_done_q <= 1'b0;
         code_q     <= '0;
         clr_pend_q <= 1'b0;
         wr_n_q     <= 1'b1;
         ld_n_q     <= 1'b1;
         clr_n_q    <= 1'b1;
      end else begin
         state_q    <= state_d;
         clr_pend_q <= (state_q == ST_IDLE) ? 1'b0 : clr_owed;
         if (accept) begin
            byte_q     <= byte_req;
            low_done_q <= 1'b0;
            code_q     <= req_code;
         end else if (state_q == ST_GAP && state_d == ST_WRITE) begin
            low_done_q <= 1'b1;
         end
         wr_n_q  <= (state_d != ST_WRITE);
         ld_n_q  <= (state_d != ST_LOAD);
         clr_n_q <= (state_d != ST_CLEAR);
      end
   end

   pdac_phase_timer #(
      .CNT_W (CNT_W)
   ) timer_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (state_d != state_q),
      .load_val (CNT_LOAD),
      .done     (timer_done)
   );

   pdac_lane_drv #(
      .DATA_W       (CODE_W),
      .BYTE_MODE_EN (BYTE_MODE_EN)
   ) lane_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (lane_start),
      .stop    (lane_stop),
      .lane    (lane_sel),
      .code    (lane_code),
      .data    (dac_data),
      .cs_hi_n (dac_cs_hi_n),
      .cs_lo_n (dac_cs_lo_n)
   );

   assign dac_wr_n    = wr_n_q;
   assign dac_load_n  = ld_n_q;
   assign dac_clear_n = clr_n_q;

endmodule

// File: rtl/pdac_wr_seq_chk.sv
module pdac_wr_seq_chk
   import pdac_wr_seq_pkg::*;
#(
   parameter int CODE_W        = 16,
   parameter int CLK_PERIOD_PS = 5000,
   parameter int MIN_PULSE_PS  = 60000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic [CODE_W-1:0] dac_data,
   input logic              dac_wr_n,
   input logic              dac_cs_hi_n,
   input logic              dac_cs_lo_n,
   input logic              dac_load_n,
   input logic              dac_clear_n
);

   localparam int PULSE_CLKS = clks_per_interval(CLK_PERIOD_PS, MIN_PULSE_PS);
   localparam int HALF_W     = CODE_W / 2;

   int wr_run, ld_run, clr_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_run  <= 0;
         ld_run  <= 0;
         clr_run <= 0;
      end else begin
         wr_run  <= dac_wr_n    ? 0 : wr_run + 1;
         ld_run  <= dac_load_n  ? 0 : ld_run + 1;
         clr_run <= dac_clear_n ? 0 : clr_run + 1;
      end
   end

   assert_wr_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dac_wr_n) |-> (wr_run == PULSE_CLKS));

   assert_wr_data_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!dac_wr_n && $past(!dac_wr_n)) |-> $stable(dac_data));

   assert_load_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dac_load_n) |-> (ld_run == PULSE_CLKS));

   assert_clear_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dac_clear_n) |-> (clr_run == PULSE_CLKS));

   assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({~dac_wr_n, ~dac_load_n, ~dac_clear_n}) <= 1);

   assert_select_in_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!dac_cs_hi_n || !dac_cs_lo_n) |-> !dac_wr_n);

   assert_ready_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (dac_wr_n && dac_load_n && dac_clear_n));

   assert_byte_replica_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!dac_wr_n && (dac_cs_hi_n != dac_cs_lo_n)) |->
         (dac_data[CODE_W-1:HALF_W] == dac_data[HALF_W-1:0]));

endmodule

bind pdac_wr_seq pdac_wr_seq_chk #(
   .CODE_W        (CODE_W),
   .CLK_PERIOD_PS (CLK_PERIOD_PS),
   .MIN_PULSE_PS  (MIN_PULSE_PS)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_ready   (req_ready),
   .dac_data    (dac_data),
   .dac_wr_n    (dac_wr_n),
   .dac_cs_hi_n (dac_cs_hi_n),
   .dac_cs_lo_n (dac_cs_lo_n),
   .dac_load_n  (dac_load_n),
   .dac_clear_n (dac_clear_n)
);

// File: tb/pdac_wr_seq_tb_top.sv
`timescale 1ns/100ps
module pdac_wr_seq_tb_top;

   // 60 ns minimum interval at a 5 ns clock -> 12 clocks (R9)
   localparam int EXP_P = 12;

   typedef struct packed {
      logic        wr;
      logic        hi;
      logic        lo;
      logic        ld;
      logic        clr;
      logic [15:0] data;
   } vec_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [15:0] req_code = '0;
   logic        req_byte = 1'b0;
   logic        req_clr = 1'b0;
   logic [15:0] dac_data;
   logic        dac_wr_n, dac_cs_hi_n, dac_cs_lo_n, dac_load_n, dac_clear_n;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   pdac_wr_seq dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_ready     (req_ready),
      .req_code      (req_code),
      .req_byte_mode (req_byte),
      .clr_req       (req_clr),
      .dac_data      (dac_data),
      .dac_wr_n      (dac_wr_n),
      .dac_cs_hi_n   (dac_cs_hi_n),
      .dac_cs_lo_n   (dac_cs_lo_n),
      .dac_load_n    (dac_load_n),
      .dac_clear_n   (dac_clear_n)
   );

   task automatic chk(input string req, input string what, input logic [31:0] got,
                      input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s %s at %0t: got %h expected %h", req, what, $time, got, exp);
      end
   endtask

   function automatic vec_t mk(input logic w, input logic h, input logic l, input logic ld,
                               input logic c, input logic [15:0] d);
      vec_t v;
      v.wr = w; v.hi = h; v.lo = l; v.ld = ld; v.clr = c; v.data = d;
      return v;
   endfunction

   // behavioural reference: queue of expected output vectors, one per clock
   vec_t q[$];
   vec_t cur;
   bit   pend;
   int   wr_run;

   function automatic bit quiet(input vec_t v);
      return v.wr && v.hi && v.lo && v.ld && v.clr;
   endfunction

   always begin
      @(posedge clk);
      if (!rst_n) begin
         q.delete();
         cur    = mk(1, 1, 1, 1, 1, 16'h0000);
         pend   = 1'b0;
         wr_run = 0;
      end else begin
         if (q.size() == 0 && quiet(cur)) begin
            if (pend || req_clr) begin
               pend = 1'b0;
               repeat (EXP_P) q.push_back(mk(1, 1, 1, 1, 0, cur.data));
            end else if (req_valid) begin
               if (req_byte) begin
                  vec_t vh, vl;
                  vh = mk(0, 0, 1, 1, 1, {req_code[15:8], req_code[15:8]});
                  vl = mk(0, 1, 0, 1, 1, {req_code[7:0], req_code[7:0]});
                  repeat (EXP_P) q.push_back(vh);
                  repeat (EXP_P) q.push_back(mk(1, 1, 1, 1, 1, vh.data));
                  repeat (EXP_P) q.push_back(vl);
                  repeat (EXP_P) q.push_back(mk(1, 1, 1, 1, 1, vl.data));
                  repeat (EXP_P) q.push_back(mk(1, 1, 1, 0, 1, vl.data));
               end else begin
                  repeat (EXP_P) q.push_back(mk(0, 0, 0, 1, 1, req_code));
                  repeat (EXP_P) q.push_back(mk(1, 1, 1, 1, 1, req_code));
                  repeat (EXP_P) q.push_back(mk(1, 1, 1, 0, 1, req_code));
               end
            end
         end else if (req_clr) begin
            pend = 1'b1;
         end
         if (q.size() > 0) cur = q.pop_front();
         else              cur = mk(1, 1, 1, 1, 1, cur.data);
      end
      #1;
      if (rst_n) begin
         chk("R5", "dac_wr_n", dac_wr_n, cur.wr);
         chk("R3", "dac_cs_hi_n", dac_cs_hi_n, cur.hi);
         chk("R3", "dac_cs_lo_n", dac_cs_lo_n, cur.lo);
         chk("R4", "dac_load_n", dac_load_n, cur.ld);
         chk("R7", "dac_clear_n", dac_clear_n, cur.clr);
         chk("R2", "dac_data", dac_data, cur.data);
         chk("R6", "req_ready", req_ready,
             (q.size() == 0 && quiet(cur) && !pend && !req_clr));
         chk("R10", "strobe overlap", (!dac_wr_n) + (!dac_load_n) + (!dac_clear_n) <= 1, 1);
         if (!dac_wr_n) begin
            wr_run++;
         end else if (wr_run != 0) begin
            chk("R9", "write pulse clocks", wr_run, EXP_P);
            wr_run = 0;
         end
      end
   end

   task automatic wait_idle();
      @(negedge clk); #1;
      while (!req_ready) begin @(negedge clk); #1; end
   endtask

   task automatic send(input logic [15:0] c, input logic m);
      @(negedge clk);
      req_valid = 1'b1; req_code = c; req_byte = m;
      #1;
      while (!req_ready) begin @(negedge clk); #1; end
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic pulse_clear();
      @(negedge clk); req_clr = 1'b1;
      @(negedge clk); req_clr = 1'b0;
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      // R1: reset values
      chk("R1", "wr/cs/ld/clr idle", {dac_wr_n, dac_cs_hi_n, dac_cs_lo_n, dac_load_n, dac_clear_n}, 5'b11111);
      chk("R1", "data zero", dac_data, 16'h0000);
      chk("R1", "ready", req_ready, 1'b1);
      rst_n = 1'b1;

      send(16'hA55A, 1'b0);     // R2 word write
      wait_idle();
      send(16'h1234, 1'b1);     // R3 byte order
      wait_idle();
      send(16'hFF00, 1'b1);
      wait_idle();
      send(16'hFFFF, 1'b0);
      send(16'h00FF, 1'b1);     // R6: second request waits for ready
      wait_idle();

      pulse_clear();            // R7 stand-alone clear
      wait_idle();

      send(16'h8001, 1'b1);     // R7 clear during a transaction is deferred
      repeat (7) @(negedge clk);
      req_clr = 1'b1;
      @(negedge clk); req_clr = 1'b0;
      wait_idle();

      // R8: clear and write requested together, clear goes first
      @(negedge clk);
      req_clr = 1'b1; req_valid = 1'b1; req_code = 16'h7FFF; req_byte = 1'b0;
      #1 chk("R8", "ready low while clear owed", req_ready, 1'b0);
      @(posedge clk); #1;
      chk("R8", "clear strobe first", dac_clear_n, 1'b0);
      chk("R8", "no write yet", dac_wr_n, 1'b1);
      @(negedge clk); req_clr = 1'b0;
      #1;
      while (!req_ready) begin @(negedge clk); #1; end
      @(negedge clk); req_valid = 1'b0;
      wait_idle();

      send(16'h0000, 1'b0);
      wait_idle();
      repeat (3) @(negedge clk);
      finished = 1'b1;
      report();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL R6 watchdog: got ready=%0b expected a finished run", req_ready);
         report();
         $finish;
      end
   end

endmodule